// File: doc/BRIEF.md
# SDRAM Start-up and Refresh Sequencer

This block owns the SDRAM command pins from power-on onward. After a `start` pulse it holds the bus in the no-operation state for a long, programmable pause. It then closes every bank with a single precharge and issues a fixed number of auto-refresh commands. It finishes start-up by writing the mode word into the device's mode register. Each gap between commands is a parameter counted in clock cycles, so one netlist can serve any clock rate.

Once start-up is complete the block raises `init_done`. It then converts the device's refresh budget into a periodic request. An interval counter adds one owed refresh per period. A host arbiter sees `ref_req` and answers with `ref_grant` when the access engine has finished its burst. The sequencer then places one auto-refresh on the pins. Owed refreshes accumulate while the grant is withheld, so none is lost.

States: ST_IDLE (waiting for start), ST_PAUSE (long NOP hold), ST_PRE_ALL (precharge-all issue), ST_WAIT_RP (precharge gap), ST_INIT_REF (start-up refresh issue), ST_WAIT_INIT_RC (refresh gap during start-up), ST_MODE_SET (mode write issue), ST_WAIT_MRD (mode gap), ST_READY (done, offering refresh), ST_RUN_REF (granted refresh issue), ST_WAIT_RUN_RC (refresh gap in service).

Transitions:
- ST_IDLE→ST_PAUSE on start.
- ST_PAUSE→ST_PRE_ALL when the pause expires.
- ST_PRE_ALL→ST_WAIT_RP→ST_INIT_REF.
- ST_INIT_REF→ST_WAIT_INIT_RC.
- ST_WAIT_INIT_RC→ST_INIT_REF while refreshes remain, otherwise →ST_MODE_SET.
- ST_MODE_SET→ST_WAIT_MRD→ST_READY.
- ST_READY→ST_RUN_REF on a grant while a request is shown.
- ST_RUN_REF→ST_WAIT_RUN_RC→ST_READY.

Top module: `sdr_init_refresh_seq`

## Requirements
- R1: Out of reset, and until `start` is seen, the pins carry NOP ({cs_n,ras_n,cas_n,we_n} = 4'b0111), `init_done` and `ref_req` are low, and `cke` is high at all times.
- R2: The first command after `start` is precharge-all. It is encoded 4'b0010 with `addr[10]` = 1. It appears exactly PAUSE_CYC+1 cycles after the cycle in which `start` was driven.
- R3: The first auto-refresh (4'b0001) follows the precharge-all after exactly T_RP_CYC cycles.
- R4: Start-up issues exactly INIT_REFS auto-refresh commands, each T_RC_CYC cycles after the one before.
- R5: The mode write (4'b0000) comes T_RC_CYC cycles after the last start-up refresh. On it, `addr` equals MODE_WORD with bits 7, 8, 10 and 11 forced to 0, and `ba` is 0.
- R6: `init_done` rises exactly T_MRD_CYC cycles after the mode write and then stays high.
- R7: The interval counter starts when `init_done` rises. `ref_req` first rises REF_INTERVAL cycles after `init_done` does.
- R8: `ref_req` stays high until granted. A grant while it is high puts an auto-refresh on the pins in the next cycle, and `ref_req` is low in that cycle.
- R9: Every interval expiry adds one owed refresh, up to 2^PEND_W-1. Each owed refresh is offered and granted on its own, so two expiries without a grant yield two refreshes.
- R10: A grant while `ref_req` is low issues no command and consumes no owed refresh.
- R11: After a refresh issued in service, no other command appears, and `ref_req` stays low, for T_RC_CYC-1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins the start-up sequence |
| ref_grant | input | 1 | Arbiter grants the bus for one refresh |
| init_done | output | 1 | Start-up complete |
| ref_req | output | 1 | An owed refresh waits for the bus |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | 12 | Address pins |
| ba | output | 2 | Bank select pins |

## Verification
The bench logs every non-NOP command with its cycle number. It then checks the exact spacing between commands, so a timer that is off by one shows up as a gap of one cycle too few or too many, and a miscounted refresh loop shows up as nine or seven start-up refreshes. It checks the mode-write address against the masked word, which catches a design that passes reserved bits through. It grants while no request is shown and then confirms that the first request still arrives on time, which catches a design that drops an owed refresh on a stray grant. It lets two intervals expire without a grant and expects two separate refreshes. A design that loses pending refreshes stops after one, and one that re-raises the request during the refresh gap shows it too early.

// File: rtl/sdr_seq_pkg.sv
package sdr_seq_pkg;

    typedef enum logic [3:0] {
        CMD_MODE_SET = 4'b0000,
        CMD_AUTO_REF = 4'b0001,
        CMD_PRECHG   = 4'b0010,
        CMD_NOP      = 4'b0111
    } sdr_cmd_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PAUSE,
        ST_PRE_ALL,
        ST_WAIT_RP,
        ST_INIT_REF,
        ST_WAIT_INIT_RC,
        ST_MODE_SET,
        ST_WAIT_MRD,
        ST_READY,
        ST_RUN_REF,
        ST_WAIT_RUN_RC
    } seq_state_e;

endpackage

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

    AST_TIMER_STAYS_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired); // R11

endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
    parameter int INTERVAL = 1950,
    parameter int PEND_W   = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic take,
    output logic pending
);

    localparam int CNT_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);
    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    logic [CNT_W-1:0]  int_q;
    logic [PEND_W-1:0] pend_q;
    logic              tick;
    logic              grow;
    logic              shrink;

    assign tick    = enable && (int_q == LAST);
    assign grow    = tick && (pend_q != PEND_MAX);
    assign shrink  = take && (pend_q != '0);
    assign pending = (pend_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q <= '0;
        end else if (!enable || tick) begin
            int_q <= '0;
        end else begin
            int_q <= int_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            unique case ({grow, shrink})
                2'b10:   pend_q <= pend_q + 1'b1;
                2'b01:   pend_q <= pend_q - 1'b1;
                default: pend_q <= pend_q;
            endcase
        end
    end

    AST_PEND_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == PEND_MAX && !take) |=> (pend_q == PEND_MAX)); // R9
    AST_PEND_TAKE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pending && !tick) |=> (pend_q == $past(pend_q) - 1'b1)); // R9
    AST_NO_TICK_BEFORE_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (int_q == '0)); // R7

endmodule

// File: rtl/sdr_init_refresh_seq.sv
module sdr_init_refresh_seq
    import sdr_seq_pkg::*;
#(
    parameter int PAUSE_CYC    = 25_000_000,
    parameter int T_RP_CYC     = 4,
    parameter int T_RC_CYC     = 10,
    parameter int T_MRD_CYC    = 2,
    parameter int INIT_REFS    = 8,
    parameter int REF_INTERVAL = 1950,
    parameter int PEND_W       = 4,
    parameter int ADDR_W       = 12,
    parameter int BA_W         = 2,
    parameter logic [ADDR_W-1:0] MODE_WORD = 12'h023
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ref_grant,
    output logic              init_done,
    output logic              ref_req,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int LONGEST = max_of(max_of(PAUSE_CYC, T_RP_CYC), max_of(T_RC_CYC, T_MRD_CYC));
    localparam int TMR_W   = $clog2(LONGEST + 1);
    localparam int REFC_W  = $clog2(INIT_REFS + 1);
    localparam int AP_BIT  = 10;
    localparam logic [ADDR_W-1:0] RSVD_BITS =
        (ADDR_W'(1) << 7) | (ADDR_W'(1) << 8) | (ADDR_W'(1) << 10) | (ADDR_W'(1) << 11);
    localparam logic [ADDR_W-1:0] MODE_SAFE = MODE_WORD & ~RSVD_BITS;

    seq_state_e state_q, state_d;
    sdr_cmd_e   cmd;
    logic [REFC_W-1:0] refs_q;
    logic [TMR_W-1:0]  load_val;
    logic              load;
    logic              expired;
    logic              pending;
    logic              take;
    logic              in_service;

    assign in_service = (state_q == ST_READY) || (state_q == ST_RUN_REF) ||
                        (state_q == ST_WAIT_RUN_RC);
    assign ref_req    = (state_q == ST_READY) && pending;
    assign take       = ref_req && ref_grant;

    sdr_wait_timer #(.W(TMR_W)) u_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sdr_ref_timer #(.INTERVAL(REF_INTERVAL), .PEND_W(PEND_W)) u_ref_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (in_service),
        .take    (take),
        .pending (pending)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            refs_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_INIT_REF) begin
                refs_q <= refs_q + 1'b1;
            end
        end
    end

    // next state and timer loads
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d  = ST_PAUSE;
                    load     = 1'b1;
                    load_val = TMR_W'(PAUSE_CYC - 1);
                end
            end
            ST_PAUSE: begin
                if (expired) state_d = ST_PRE_ALL;
            end
            ST_PRE_ALL: begin
                state_d  = ST_WAIT_RP;
                load     = 1'b1;
                load_val = TMR_W'(T_RP_CYC - 2);
            end
            ST_WAIT_RP: begin
                if (expired) state_d = ST_INIT_REF;
            end
            ST_INIT_REF: begin
                state_d  = ST_WAIT_INIT_RC;
                load     = 1'b1;
                load_val = TMR_W'(T_RC_CYC - 2);
            end
            ST_WAIT_INIT_RC: begin
                if (expired) begin
                    state_d = (refs_q == REFC_W'(INIT_REFS)) ? ST_MODE_SET : ST_INIT_REF;
                end
            end
            ST_MODE_SET: begin
                state_d  = ST_WAIT_MRD;
                load     = 1'b1;
                load_val = TMR_W'(T_MRD_CYC - 2);
            end
            ST_WAIT_MRD: begin
                if (expired) state_d = ST_READY;
            end
            ST_READY: begin
                if (take) state_d = ST_RUN_REF;
            end
            ST_RUN_REF: begin
                state_d  = ST_WAIT_RUN_RC;
                load     = 1'b1;
                load_val = TMR_W'(T_RC_CYC - 2);
            end
            ST_WAIT_RUN_RC: begin
                if (expired) state_d = ST_READY;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // pin outputs
    always_comb begin
        cmd  = CMD_NOP;
        addr = '0;
        ba   = '0;
        unique case (state_q)
            ST_PRE_ALL: begin
                cmd          = CMD_PRECHG;
                addr[AP_BIT] = 1'b1;
            end
            ST_INIT_REF, ST_RUN_REF: cmd = CMD_AUTO_REF;
            ST_MODE_SET: begin
                cmd  = CMD_MODE_SET;
                addr = MODE_SAFE;
            end
            default: cmd = CMD_NOP;
        endcase
    end

    assign {cs_n, ras_n, cas_n, we_n} = cmd;
    assign cke       = 1'b1;
    assign init_done = in_service;

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && !ref_grant) |=> ref_req); // R8
    AST_GRANT_GIVES_REF: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_req && ref_grant) |=> ({cs_n, ras_n, cas_n, we_n} == CMD_AUTO_REF && !ref_req)); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done); // R6
    AST_MODE_AFTER_ALL_REFS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_MODE_SET) |-> (refs_q == REFC_W'(INIT_REFS))); // R4
    AST_IDLE_UNTIL_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE)); // R1

endmodule

// File: tb/sdr_init_refresh_seq_tb.sv
module sdr_init_refresh_seq_tb;

    localparam int PAUSE = 50;
    localparam int TRP   = 3;
    localparam int TRC   = 10;
    localparam int TMRD  = 2;
    localparam int NREF  = 8;
    localparam int IVL   = 200;
    localparam logic [11:0] MODE_IN  = 12'hFA3;
    localparam logic [11:0] MODE_EXP = 12'h223;
    localparam logic [3:0] C_NOP = 4'b0111, C_PRE = 4'b0010, C_REF = 4'b0001, C_MRS = 4'b0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic ref_grant = 1'b0;
    logic init_done, ref_req, cke, cs_n, ras_n, cas_n, we_n;
    logic [11:0] addr;
    logic [1:0]  ba;

    always #5 clk = ~clk;

    sdr_init_refresh_seq #(
        .PAUSE_CYC(PAUSE), .T_RP_CYC(TRP), .T_RC_CYC(TRC), .T_MRD_CYC(TMRD),
        .INIT_REFS(NREF), .REF_INTERVAL(IVL), .PEND_W(3), .ADDR_W(12), .BA_W(2),
        .MODE_WORD(MODE_IN)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_grant(ref_grant),
        .init_done(init_done), .ref_req(ref_req), .cke(cke),
        .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .addr(addr), .ba(ba)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int n_cmd = 0;
    int cke_low = 0;
    int done_cyc = -1;
    int c_cyc [64];
    logic [3:0]  c_code [64];
    logic [11:0] c_addr [64];
    logic [1:0]  c_ba [64];
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if ({cs_n, ras_n, cas_n, we_n} != C_NOP && n_cmd < 64) begin
                c_cyc[n_cmd]  = cyc;
                c_code[n_cmd] = {cs_n, ras_n, cas_n, we_n};
                c_addr[n_cmd] = addr;
                c_ba[n_cmd]   = ba;
                n_cmd = n_cmd + 1;
            end
            if (!cke) cke_low = cke_low + 1;
            if (init_done && done_cyc < 0) done_cyc = cyc;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_grant();
        ref_grant = 1'b1;
        step();
        ref_grant = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) step();
        check({cs_n, ras_n, cas_n, we_n} == C_NOP, "R1 reset pins", {cs_n, ras_n, cas_n, we_n}, C_NOP);
        check(!init_done && !ref_req, "R1 reset flags", {init_done, ref_req}, 0);
        check(cke == 1'b1, "R1 cke", cke, 1);
        rst_n = 1'b1;
        repeat (30) step();
        check(n_cmd == 0 && !init_done, "R1 no start no command", n_cmd, 0);
    endtask

    task automatic t_init();
        int s;
        s = cyc;
        start = 1'b1;
        step();
        start = 1'b0;
        while (done_cyc < 0) step();
        check(c_code[0] == C_PRE, "R2 first cmd precharge", c_code[0], C_PRE);
        check(c_cyc[0] - s == PAUSE + 1, "R2 pause length", c_cyc[0] - s, PAUSE + 1);
        check(c_addr[0][10] == 1'b1, "R2 all-bank bit", c_addr[0][10], 1);
        check(c_code[1] == C_REF && c_cyc[1] - c_cyc[0] == TRP, "R3 precharge gap",
              c_cyc[1] - c_cyc[0], TRP);
        for (int i = 2; i <= NREF; i++) begin
            check(c_code[i] == C_REF && c_cyc[i] - c_cyc[i-1] == TRC, "R4 refresh gap",
                  c_cyc[i] - c_cyc[i-1], TRC);
        end
        check(n_cmd == NREF + 2, "R4 command count", n_cmd, NREF + 2);
        check(c_code[NREF+1] == C_MRS && c_cyc[NREF+1] - c_cyc[NREF] == TRC, "R5 mode write gap",
              c_cyc[NREF+1] - c_cyc[NREF], TRC);
        check(c_addr[NREF+1] == MODE_EXP && c_ba[NREF+1] == 2'b00, "R5 mode address",
              c_addr[NREF+1], MODE_EXP);
        check(done_cyc - c_cyc[NREF+1] == TMRD, "R6 done delay", done_cyc - c_cyc[NREF+1], TMRD);
    endtask

    task automatic t_stray_grant_then_first_req();
        while (cyc < done_cyc + 20) step();
        pulse_grant();
        repeat (3) step();
        check(n_cmd == NREF + 2, "R10 stray grant no command", n_cmd, NREF + 2);
        check(init_done == 1'b1, "R6 done stays", init_done, 1);
        while (!ref_req) step();
        check(cyc - done_cyc == IVL, "R7 first request time", cyc - done_cyc, IVL);
    endtask

    task automatic t_grant();
        int g;
        repeat (5) step();
        check(ref_req == 1'b1, "R8 request held", ref_req, 1);
        g = cyc;
        pulse_grant();
        check(ref_req == 1'b0, "R8 request drops", ref_req, 0);
        check(n_cmd == NREF + 3 && c_code[NREF+2] == C_REF && c_cyc[NREF+2] == g + 1,
              "R8 refresh next cycle", c_cyc[NREF+2] - g, 1);
        repeat (TRC) step();
        check(ref_req == 1'b0 && n_cmd == NREF + 3, "R11 quiet after refresh", n_cmd, NREF + 3);
    endtask

    task automatic t_accumulate();
        int g;
        while (cyc < done_cyc + 3 * IVL + 5) step();
        check(ref_req == 1'b1, "R9 owed refresh shown", ref_req, 1);
        g = cyc;
        pulse_grant();
        repeat (TRC - 1) step();
        check(ref_req == 1'b0 && n_cmd == NREF + 4, "R11 gap holds request", ref_req, 0);
        step();
        check(ref_req == 1'b1, "R9 second owed refresh", ref_req, 1);
        pulse_grant();
        check(n_cmd == NREF + 5 && c_cyc[NREF+4] - c_cyc[NREF+3] >= TRC, "R11 refresh spacing",
              c_cyc[NREF+4] - c_cyc[NREF+3], TRC + 1);
        check(c_cyc[NREF+3] == g + 1, "R9 first of two", c_cyc[NREF+3] - g, 1);
        repeat (15) step();
        check(ref_req == 1'b0, "R9 both consumed", ref_req, 0);
        check(cke_low == 0, "R1 cke never low", cke_low, 0);
    endtask

    initial begin
        t_reset();
        t_init();
        t_stray_grant_then_first_req();
        t_grant();
        t_accumulate();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks = checks + 1;
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule